// File: doc/BRIEF.md
# Scanline-Paced Sound Register Command Sequencer

This block runs three independent command streams that program a sound generator's register file with no help from the processor. Each stream lives in RAM as a list of 16-bit words. After each horizontal sync the sequencer reads one word for every channel that is ready, and then carries those words out in channel order. Its commands can write a sound register, wait a number of scaled scanlines, repeat a section of the list, raise an interrupt, or halt the stream.

The host sets up a start address and a pause scale for each channel through a small register port. It then starts the channels through a shared control/status byte. That byte also reports per-channel interrupt flags and mirrors a raster interrupt line from outside the block. All timing is counted in 1 µs strobes (`us_tick`). The sound-register write port can be held off with a busy input.

Top module: `snd_cmd_seq`

## Requirements
- R1: A word 0RDDh (bits 15:12 = 0) produces one `psg_we` pulse with `psg_reg` = R (bits 11:8) and `psg_data` = DD (bits 7:0).
- R2: On a rising edge of `hsync` while idle, the first `us_tick` is a dead slot. Each following `us_tick` is one fetch slot per active channel, in ascending channel order, and then one execute slot per active channel in the same order. `mem_req` is high only during fetch slots. An active channel is enabled with a pause count of zero.
- R3: A LOAD occupies its execute slot plus seven more ticks, so its `psg_we` follows the seventh tick after the execute slot. If `psg_busy` is high at that tick, the write is retried on each later tick until `psg_busy` is low. `psg_we` lasts one clock.
- R4: PAUSE M (1NNNh, M > 0) with scale register value N means the channel's next instruction executes exactly M×(N+1) scanlines after the scanline that held the PAUSE. Meanwhile the channel uses neither a fetch slot nor an execute slot.
- R5: REPEAT N (2NNNh) loads the loop count with N and records the address of the next word. LOOP (4001h) jumps to that address and decrements the count when the count is nonzero, and falls through when it is zero, so the loop body runs N+1 times.
- R6: NOP (4000h), any 3xxxh word, PAUSE 0 and any other 4xxxh word only consume their execute slot. They produce no register write and no change of state.
- R7: INT (4010h) sets the channel's flag: bit 6 for channel 0, bit 5 for channel 1, bit 4 for channel 2. `irq` is the OR of the flags. Writing 1 to a flag bit clears it.
- R8: Bits 2:0 of the control byte (address Fh) are the enables of channels 2..0. A write stores them, a STOP (4020h) clears the issuing channel's bit, and reset clears them all.
- R9: Reading address Fh returns `raster_irq` in bit 7, the flags in bits 6:4, 0 in bit 3 and the enables in bits 2:0. Writes to bit 7 have no effect.
- R10: Channel c's start address is at 4c (low byte) and 4c+1 (high byte), and its scale is at 4c+2. Fetches always use an even address with bit 0 cleared, and the address advances by 2 after each fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hsync | input | 1 | Horizontal sync level; its rising edge starts a scanline |
| us_tick | input | 1 | One-clock strobe every 1 µs |
| mem_req | output | 1 | Fetch slot in progress |
| mem_addr | output | 16 | Byte address of the word being fetched (always even) |
| mem_rdata | input | 16 | Word read at mem_addr, valid while mem_req is high |
| cpu_we | input | 1 | Host register write strobe |
| cpu_addr | input | 4 | Host register address |
| cpu_wdata | input | 8 | Host write data |
| cpu_rdata | output | 8 | Control/status byte at address Fh, zero elsewhere |
| raster_irq | input | 1 | Raster interrupt state mirrored into status bit 7 |
| psg_we | output | 1 | Sound register write pulse |
| psg_reg | output | 4 | Sound register index |
| psg_data | output | 8 | Sound register data |
| psg_busy | input | 1 | Holds off a pending sound register write |
| irq | output | 1 | Any channel interrupt flag set |

## Verification
The checks assume that `mem_rdata` is valid combinationally during a fetch slot. They also assume that scanlines are long enough for the whole slot sequence to finish before the next `hsync` edge, and that `us_tick` never coincides with the edge. The stimulus spaces `hsync` 40 ticks apart, so it exceeds the worst case of 28 ticks. It raises `hsync` only on clocks without a tick and changes the host registers only while the sequencer is idle. `psg_busy` changes only between ticks.

// File: rtl/snd_seq_pkg.sv
package snd_seq_pkg;

    localparam int CH_NUM = 3;
    localparam int CH_W   = $clog2(CH_NUM);
    localparam int AW     = 16;
    localparam int WW     = 16;
    localparam int PRE_W  = 8;
    localparam int CNT_W  = 12;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_PAUSE,
        OP_REPEAT,
        OP_LOOP,
        OP_INT,
        OP_STOP
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEAD,
        ST_FETCH,
        ST_EXEC,
        ST_LOAD
    } slot_st_e;

    typedef struct packed {
        logic [AW-1:0]    sar;
        logic [PRE_W-1:0] ppr;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] pause;
        logic [CNT_W-1:0] loop_cnt;
        logic [AW-1:0]    loop_addr;
        logic [WW-1:0]    instr;
    } chan_st_t;

    typedef struct packed {
        logic [CH_NUM-1:0] en;
        logic [CH_NUM-1:0] flag;
    } csr_st_t;

    // Classify an instruction word.
    function automatic op_e decode_op(input logic [WW-1:0] w);
        op_e r;
        r = OP_NONE;
        case (w[15:12])
            4'h0: r = OP_LOAD;
            4'h1: r = (w[11:0] != '0) ? OP_PAUSE : OP_NONE;
            4'h2: r = OP_REPEAT;
            4'h4: begin
                case (w[11:0])
                    12'h001: r = OP_LOOP;
                    12'h010: r = OP_INT;
                    12'h020: r = OP_STOP;
                    default: r = OP_NONE;
                endcase
            end
            default: r = OP_NONE;
        endcase
        return r;
    endfunction

    // Lowest set channel at or above 'from'; MSB flags a hit.
    function automatic logic [CH_W:0] pick_next(input logic [CH_NUM-1:0] m, input int from);
        logic [CH_W:0] r;
        r = '0;
        for (int c = CH_NUM - 1; c >= 0; c--) begin
            if (c >= from && m[c]) r = {1'b1, CH_W'(c)};
        end
        return r;
    endfunction

endpackage

// File: rtl/snd_seq_chan.sv
module snd_seq_chan
    import snd_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_pre,
    input  logic [7:0]       wdata,
    input  logic             line_go,
    input  logic             fetch_go,
    input  logic [WW-1:0]    fetch_word,
    input  logic             exec_go,
    output logic [AW-1:0]    fetch_addr,
    output logic [WW-1:0]    instr,
    output logic             ready,
    output logic             int_pulse,
    output logic             stop_pulse
);

    chan_st_t q, d;
    op_e      op;

    always_comb begin
        d          = q;
        int_pulse  = 1'b0;
        stop_pulse = 1'b0;
        op         = decode_op(q.instr);

        // prescaled countdown of a pending pause, once per scanline
        if (line_go && q.pause != '0) begin
            if (q.pre == '0) begin
                d.pause = q.pause - 1'b1;
                d.pre   = q.ppr;
            end else begin
                d.pre = q.pre - 1'b1;
            end
        end

        if (fetch_go) begin
            d.instr = fetch_word;
            d.sar   = {q.sar[AW-1:1], 1'b0} + AW'(2);
        end

        if (exec_go) begin
            case (op)
                OP_PAUSE: begin
                    d.pause = q.instr[CNT_W-1:0];
                    d.pre   = q.ppr;
                end
                OP_REPEAT: begin
                    d.loop_cnt  = q.instr[CNT_W-1:0];
                    d.loop_addr = q.sar;
                end
                OP_LOOP: begin
                    if (q.loop_cnt != '0) begin
                        d.sar      = q.loop_addr;
                        d.loop_cnt = q.loop_cnt - 1'b1;
                    end
                end
                OP_INT:  int_pulse  = 1'b1;
                OP_STOP: stop_pulse = 1'b1;
                default: ;
            endcase
        end

        // host writes take priority over the sequencer
        if (wr_lo)  d.sar[7:0]    = wdata;
        if (wr_hi)  d.sar[AW-1:8] = wdata[AW-9:0];
        if (wr_pre) d.ppr         = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fetch_addr = {q.sar[AW-1:1], 1'b0};
    assign instr      = q.instr;
    assign ready      = (q.pause == '0);

endmodule

// File: rtl/snd_seq_csr.sv
module snd_seq_csr
    import snd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [7:0]        wdata,
    input  logic [CH_NUM-1:0] int_set,
    input  logic [CH_NUM-1:0] stop_clr,
    input  logic              raster_irq,
    output logic [CH_NUM-1:0] en,
    output logic [7:0]        rdata,
    output logic              irq
);

    csr_st_t q, d;
    logic    unused_wbits;

    assign unused_wbits = ^{wdata[7], wdata[3]};

    always_comb begin
        d = q;
        for (int c = 0; c < CH_NUM; c++) begin
            if (csr_we)           d.en[c] = wdata[c];
            else if (stop_clr[c]) d.en[c] = 1'b0;

            if (int_set[c])                 d.flag[c] = 1'b1;
            else if (csr_we && wdata[6-c])  d.flag[c] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata    = '0;
        rdata[7] = raster_irq;
        for (int c = 0; c < CH_NUM; c++) begin
            rdata[c]   = q.en[c];
            rdata[6-c] = q.flag[c];
        end
    end

    assign en  = q.en;
    assign irq = |q.flag;

endmodule

// File: rtl/snd_seq_slot.sv
module snd_seq_slot
    import snd_seq_pkg::*;
#(
    parameter int LOAD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              line_go,
    input  logic [CH_NUM-1:0] en,
    input  logic [CH_NUM-1:0] ready,
    input  logic [CH_NUM-1:0] is_load,
    input  logic [WW-1:0]     cur_instr,
    input  logic              psg_busy,
    output logic              idle,
    output logic [CH_NUM-1:0] fetch_go,
    output logic [CH_NUM-1:0] exec_go,
    output logic              mem_req,
    output logic [CH_W-1:0]   sel_ch,
    output logic              psg_we,
    output logic [3:0]        psg_reg,
    output logic [7:0]        psg_data
);

    localparam int LC_W      = $clog2(LOAD_CYCLES);
    localparam int LOAD_LAST = LOAD_CYCLES - 2;

    typedef struct packed {
        slot_st_e          st;
        logic [CH_W-1:0]   ch;
        logic [CH_NUM-1:0] mask;
        logic [LC_W-1:0]   lcnt;
        logic              psg_we;
        logic [3:0]        psg_reg;
        logic [7:0]        psg_data;
    } slot_t;

    slot_t         q, d;
    logic [CH_W:0] nxt;
    logic [CH_W:0] first;
    logic [3:0]    unused_op;

    assign unused_op = cur_instr[15:12];

    always_comb begin
        d        = q;
        d.psg_we = 1'b0;
        fetch_go = '0;
        exec_go  = '0;
        nxt      = pick_next(q.mask, int'(q.ch) + 1);
        first    = pick_next(q.mask, 0);

        case (q.st)
            ST_IDLE: begin
                if (line_go) d.st = ST_DEAD;
            end
            ST_DEAD: begin
                if (us_tick) begin
                    d.mask = en & ready;
                    first  = pick_next(en & ready, 0);
                    if (first[CH_W]) begin
                        d.st = ST_FETCH;
                        d.ch = first[CH_W-1:0];
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_FETCH: begin
                if (us_tick) begin
                    fetch_go[q.ch] = 1'b1;
                    if (nxt[CH_W]) begin
                        d.ch = nxt[CH_W-1:0];
                    end else begin
                        d.st = ST_EXEC;
                        d.ch = first[CH_W-1:0];
                    end
                end
            end
            ST_EXEC: begin
                if (us_tick) begin
                    if (is_load[q.ch]) begin
                        d.st   = ST_LOAD;
                        d.lcnt = '0;
                    end else begin
                        exec_go[q.ch] = 1'b1;
                        if (nxt[CH_W]) d.ch = nxt[CH_W-1:0];
                        else           d.st = ST_IDLE;
                    end
                end
            end
            ST_LOAD: begin
                if (us_tick) begin
                    if (q.lcnt != LC_W'(LOAD_LAST)) begin
                        d.lcnt = q.lcnt + 1'b1;
                    end else if (!psg_busy) begin
                        d.psg_we   = 1'b1;
                        d.psg_reg  = cur_instr[11:8];
                        d.psg_data = cur_instr[7:0];
                        if (nxt[CH_W]) begin
                            d.st = ST_EXEC;
                            d.ch = nxt[CH_W-1:0];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle     = (q.st == ST_IDLE);
    assign mem_req  = (q.st == ST_FETCH);
    assign sel_ch   = q.ch;
    assign psg_we   = q.psg_we;
    assign psg_reg  = q.psg_reg;
    assign psg_data = q.psg_data;

endmodule

// File: rtl/snd_cmd_seq.sv
module snd_cmd_seq
    import snd_seq_pkg::*;
#(
    parameter int LOAD_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync,
    input  logic          us_tick,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [WW-1:0] mem_rdata,
    input  logic          cpu_we,
    input  logic [3:0]    cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic [7:0]    cpu_rdata,
    input  logic          raster_irq,
    output logic          psg_we,
    output logic [3:0]    psg_reg,
    output logic [7:0]    psg_data,
    input  logic          psg_busy,
    output logic          irq
);

    localparam logic [3:0] CSR_ADDR = 4'hF;

    logic              hs_q, hs_d;
    logic              line_go;
    logic              seq_idle;
    logic              csr_we;
    logic [7:0]        csr_rdata;
    logic [CH_NUM-1:0] ch_en, ch_ready, ch_load;
    logic [CH_NUM-1:0] fetch_go, exec_go;
    logic [CH_NUM-1:0] int_pulse, stop_pulse;
    logic [CH_W-1:0]   sel_ch;
    logic [AW-1:0]     ch_addr  [CH_NUM];
    logic [WW-1:0]     ch_instr [CH_NUM];

    always_comb hs_d = hsync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= 1'b0;
        else        hs_q <= hs_d;
    end

    assign line_go = hsync & ~hs_q & seq_idle;
    assign csr_we  = cpu_we && (cpu_addr == CSR_ADDR);

    for (genvar c = 0; c < CH_NUM; c++) begin : g_chan
        localparam logic [3:0] BASE = 4'(4 * c);

        snd_seq_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_lo      (cpu_we && cpu_addr == BASE),
            .wr_hi      (cpu_we && cpu_addr == BASE + 4'd1),
            .wr_pre     (cpu_we && cpu_addr == BASE + 4'd2),
            .wdata      (cpu_wdata),
            .line_go    (line_go),
            .fetch_go   (fetch_go[c]),
            .fetch_word (mem_rdata),
            .exec_go    (exec_go[c]),
            .fetch_addr (ch_addr[c]),
            .instr      (ch_instr[c]),
            .ready      (ch_ready[c]),
            .int_pulse  (int_pulse[c]),
            .stop_pulse (stop_pulse[c])
        );

        assign ch_load[c] = (decode_op(ch_instr[c]) == OP_LOAD);
    end

    snd_seq_slot #(.LOAD_CYCLES(LOAD_CYCLES)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .line_go   (line_go),
        .en        (ch_en),
        .ready     (ch_ready),
        .is_load   (ch_load),
        .cur_instr (ch_instr[sel_ch]),
        .psg_busy  (psg_busy),
        .idle      (seq_idle),
        .fetch_go  (fetch_go),
        .exec_go   (exec_go),
        .mem_req   (mem_req),
        .sel_ch    (sel_ch),
        .psg_we    (psg_we),
        .psg_reg   (psg_reg),
        .psg_data  (psg_data)
    );

    snd_seq_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_we     (csr_we),
        .wdata      (cpu_wdata),
        .int_set    (int_pulse),
        .stop_clr   (stop_pulse),
        .raster_irq (raster_irq),
        .en         (ch_en),
        .rdata      (csr_rdata),
        .irq        (irq)
    );

    assign mem_addr  = ch_addr[sel_ch];
    assign cpu_rdata = (cpu_addr == CSR_ADDR) ? csr_rdata : 8'h00;

endmodule

// File: rtl/snd_seq_chk.sv
module snd_seq_chk
    import snd_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              psg_we,
    input logic              psg_busy,
    input logic              mem_req,
    input logic              irq,
    input logic              csr_we,
    input logic [CH_NUM-1:0] fetch_go,
    input logic [CH_NUM-1:0] ch_en,
    input logic [CH_NUM-1:0] int_pulse,
    input logic [CH_NUM-1:0] stop_pulse
);

    // R3
    psg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psg_we |=> !psg_we);

    // R3
    psg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psg_we |-> !$past(psg_busy));

    // R2
    fetch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_go));

    // R2
    fetch_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && psg_we));

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|int_pulse));

    for (genvar c = 0; c < CH_NUM; c++) begin : g_en
        // R8
        en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_en[c]) |-> ($past(csr_we) || $past(stop_pulse[c])));
    end

endmodule

bind snd_cmd_seq snd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .psg_we     (psg_we),
    .psg_busy   (psg_busy),
    .mem_req    (mem_req),
    .irq        (irq),
    .csr_we     (csr_we),
    .fetch_go   (fetch_go),
    .ch_en      (ch_en),
    .int_pulse  (int_pulse),
    .stop_pulse (stop_pulse)
);

// File: tb/tb_snd_cmd_seq.sv
`timescale 1ns/1ps
module tb_snd_cmd_seq;

    localparam int CLK_NS = 10;
    localparam int LINE_CLKS = 80;
    localparam int N_EXP = 8;

    // {line, tick, reg, data}
    localparam logic [31:0] EXP_W [N_EXP] = '{
        {8'd1,  8'd12, 8'h0A, 8'h11},
        {8'd1,  8'd20, 8'h01, 8'h55},
        {8'd3,  8'd11, 8'h0B, 8'h22},
        {8'd3,  8'd19, 8'h0F, 8'h77},
        {8'd5,  8'd10, 8'h0B, 8'h22},
        {8'd6,  8'd12, 8'h02, 8'h66},
        {8'd7,  8'd11, 8'h0B, 8'h22},
        {8'd12, 8'd10, 8'h0C, 8'h33}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hsync, us_tick;
    logic        mem_req;
    logic [15:0] mem_addr, mem_rdata;
    logic        cpu_we;
    logic [3:0]  cpu_addr;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic        raster_irq, psg_we, psg_busy, irq;
    logic [3:0]  psg_reg;
    logic [7:0]  psg_data;

    logic [15:0] ram [512];
    logic        lines_on = 1'b0;
    int          lpos = 0;
    logic        hs_prev = 1'b0;
    logic [7:0]  line_no = '0;
    logic [7:0]  tcount = '0;
    logic [31:0] wlog [16];
    int          nlog = 0, nfetch = 0, nodd = 0;
    int          n_tests = 0, n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    assign mem_rdata = ram[mem_addr[9:1]];

    snd_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .us_tick(us_tick),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .raster_irq(raster_irq), .psg_we(psg_we), .psg_reg(psg_reg), .psg_data(psg_data),
        .psg_busy(psg_busy), .irq(irq)
    );

    // scanline and microsecond strobe generator
    initial begin
        hsync = 1'b0;
        us_tick = 1'b0;
        forever begin
            @(negedge clk);
            if (lines_on) begin
                hsync   = (lpos < 4);
                us_tick = lpos[0];
                lpos    = (lpos == LINE_CLKS - 1) ? 0 : lpos + 1;
            end else begin
                hsync   = 1'b0;
                us_tick = 1'b0;
                lpos    = 0;
            end
        end
    end

    // line and tick position as seen by the design
    always @(posedge clk) begin
        hs_prev <= hsync;
        if (hsync && !hs_prev) begin
            line_no <= line_no + 8'd1;
            tcount  <= '0;
        end else if (us_tick) begin
            tcount <= tcount + 8'd1;
        end
        if (rst_n && mem_req && us_tick) nfetch <= nfetch + 1;
        if (rst_n && mem_req && mem_addr[0]) nodd <= nodd + 1;
    end

    always @(negedge clk) begin
        if (rst_n && psg_we && nlog < 16) begin
            wlog[nlog] = {line_no, tcount, 4'h0, psg_reg, psg_data};
            nlog = nlog + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        cpu_addr = a;
        #1;
        v = cpu_rdata;
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        raster_irq = 1'b0; psg_busy = 1'b0;
        for (int i = 0; i < 512; i++) ram[i] = 16'h4000;
        // channel 0 at byte 0100h
        ram[9'h080] = 16'h0A11; ram[9'h081] = 16'h2002; ram[9'h082] = 16'h0B22;
        ram[9'h083] = 16'h4001; ram[9'h084] = 16'h1003; ram[9'h085] = 16'h0C33;
        ram[9'h086] = 16'h4010; ram[9'h087] = 16'h4020; ram[9'h088] = 16'h0D44;
        // channel 1 at byte 0200h
        ram[9'h100] = 16'h0155; ram[9'h101] = 16'h1002; ram[9'h102] = 16'h0266;
        ram[9'h103] = 16'h4020;
        // channel 2 at byte 0300h (programmed odd)
        ram[9'h180] = 16'h4000; ram[9'h181] = 16'h3ABC; ram[9'h182] = 16'h0F77;
        ram[9'h183] = 16'h4020;
        // busy test program at byte 0380h
        ram[9'h1C0] = 16'h0399; ram[9'h1C1] = 16'h04AA; ram[9'h1C2] = 16'h4020;

        repeat (5) @(posedge clk);
        rst_n = 1'b1;

        // reset state, R8 R9 R7
        cpu_read(4'hF, rd);
        check("R8 R9 reset status", 32'(rd), 32'h00);
        check("R7 reset irq", 32'(irq), 32'h0);
        check("R2 reset mem_req", 32'(mem_req), 32'h0);

        // R10 address set-up
        cpu_write(4'h0, 8'h00); cpu_write(4'h1, 8'h01); cpu_write(4'h2, 8'h00);
        cpu_write(4'h4, 8'h00); cpu_write(4'h5, 8'h02); cpu_write(4'h6, 8'h01);
        cpu_write(4'h8, 8'h01); cpu_write(4'h9, 8'h03); cpu_write(4'hA, 8'h00);
        cpu_write(4'hF, 8'h07);
        cpu_read(4'hF, rd);
        check("R8 enables set", 32'(rd), 32'h07);

        @(posedge clk);
        lines_on = 1'b1;
        wait (line_no == 8'd16 && tcount == 8'd30);
        @(posedge clk);
        lines_on = 1'b0;

        // table walk: R1 R3 R4 R5 R6 order and timing
        check("R5 R8 total writes", 32'(nlog), 32'(N_EXP));
        for (int i = 0; i < N_EXP; i++)
            check($sformatf("R1 R3 R4 R5 R6 write %0d", i), wlog[i], EXP_W[i]);
        check("R2 R4 fetch slots", 32'(nfetch), 32'd20);
        check("R10 even fetch address", 32'(nodd), 32'd0);

        cpu_read(4'hF, rd);
        check("R7 R8 R9 status after run", 32'(rd), 32'h40);
        check("R7 irq set", 32'(irq), 32'h1);
        raster_irq = 1'b1;
        cpu_read(4'hF, rd);
        check("R9 raster bit", 32'(rd), 32'hC0);
        raster_irq = 1'b0;
        cpu_write(4'hF, 8'hC0);
        cpu_read(4'hF, rd);
        check("R7 R9 flag clear", 32'(rd), 32'h00);
        check("R7 irq cleared", 32'(irq), 32'h0);

        // R3 busy hold-off, R8 host disable
        cpu_write(4'h0, 8'h80); cpu_write(4'h1, 8'h03);
        psg_busy = 1'b1;
        cpu_write(4'hF, 8'h01);
        @(posedge clk);
        lines_on = 1'b1;
        wait (line_no == 8'd17 && tcount == 8'd14);
        @(negedge clk);
        psg_busy = 1'b0;
        wait (line_no == 8'd17 && tcount == 8'd25);
        cpu_write(4'hF, 8'h00);
        wait (line_no == 8'd19 && tcount == 8'd30);
        @(posedge clk);
        lines_on = 1'b0;
        check("R3 busy write count", 32'(nlog), 32'd9);
        check("R3 busy write timing", wlog[8], {8'd17, 8'd15, 8'h03, 8'h99});
        check("R8 disabled channel idle", 32'(nfetch), 32'd21);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule